// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block decides, for each of the two ALU operands of an in-order five-stage pipeline, where the execute stage should take its value from. It compares the operand source register numbers held in the decode/execute pipeline register against the destination register and write enable of the two younger-result registers downstream (execute/memory and memory/writeback). It drives a 2-bit select per operand that steers the datapath operand mux. The mux can choose the value read from the register file, the ALU result waiting in execute/memory, or the final writeback value in memory/writeback. That writeback value is either loaded data or an ALU result.

A loaded value is only available once the load reaches writeback. An instruction that uses it straight after the load therefore cannot be served by any forwarding path. For that case the block also looks at the instruction in decode. When the instruction in execute is a load whose nonzero destination matches a source register that the decode instruction actually reads, the block raises a stall request. The pipeline uses that request to hold decode and insert a bubble. The block is purely combinational: every output follows its inputs within the same cycle. It has only plain control pins and no handshake.

Top module: `fwd_unit`

## Requirements
- R1: An operand select is 2'b10 (execute/memory path) when the execute/memory write enable is 1, its destination is nonzero, and its destination equals that operand's source register.
- R2: An operand select is 2'b01 (memory/writeback path) when the memory/writeback write enable is 1, its destination is nonzero, it equals the operand's source, and the R1 condition is false for that operand.
- R3: When both downstream stages write the operand's source register, the select is 2'b10: the newer result wins.
- R4: In every other case the select is 2'b00 (register file). A stage whose write enable is 0 is never forwarded from, and the code 2'b11 never appears.
- R5: An operand whose source register is 0 always selects 2'b00, whatever the downstream stages hold.
- R6: Operands A and B are decided independently by the same rules, so each can take a different path in the same cycle.
- R7: The stall request is 1 when the execute-stage instruction is a load, its destination is nonzero, and that destination equals a decode-stage source register whose use flag is 1.
- R8: The stall request is 0 when the execute-stage instruction is not a load, when the load's destination is 0, or when the matching decode source has its use flag at 0.
- R9: All outputs are combinational functions of the current inputs and have no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_AW | Operand A source register of the instruction in execute |
| ex_src_b | input | REG_AW | Operand B source register of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute is a load |
| ex_dst | input | REG_AW | Destination register of the instruction in execute |
| mem_wen | input | 1 | Execute/memory stage will write a register |
| mem_dst | input | REG_AW | Execute/memory destination register |
| wb_wen | input | 1 | Memory/writeback stage will write a register |
| wb_dst | input | REG_AW | Memory/writeback destination register |
| dec_src_a | input | REG_AW | First source register of the instruction in decode |
| dec_src_b | input | REG_AW | Second source register of the instruction in decode |
| dec_use_a | input | 1 | Decode instruction reads dec_src_a |
| dec_use_b | input | 1 | Decode instruction reads dec_src_b |
| sel_a | output | 2 | Operand A select: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Operand B select, same encoding |
| stall_req | output | 1 | Load-use hazard: hold decode and insert a bubble |

## Verification
The block holds no state. A fault in its match or priority logic therefore shows at the ports in the same cycle as the input pattern that exposes it. Examples are a stale ALU value chosen over the newer one, a forward from a stage that is not writing, a forward of register 0, or an operand coupled to the other operand's result. The bench models the operand mux and the ALU. A wrong select shows both as a wrong select code and as a wrong ALU result in that cycle. A missed load-use stall is just as immediate: stall_req stays low on the very pattern that needs the bubble.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB      = 2'b01,
    SEL_MEM     = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_hit.sv
// One comparison: does a writing stage produce the register a consumer reads?
module fwd_hit #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] dst,
  input  logic              wen,
  output logic              hit
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;
  assign hit = wen && (dst != ZERO_REG) && (dst == src);
endmodule

// File: rtl/fwd_operand_sel.sv
// Priority select for one ALU operand.
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              wb_wen,
  input  logic [REG_AW-1:0] wb_dst,
  output fwd_sel_e          sel
);
  logic mem_hit, wb_hit;

  fwd_hit #(.REG_AW(REG_AW)) u_mem_hit (
    .src(src), .dst(mem_dst), .wen(mem_wen), .hit(mem_hit)
  );
  fwd_hit #(.REG_AW(REG_AW)) u_wb_hit (
    .src(src), .dst(wb_dst), .wen(wb_wen), .hit(wb_hit)
  );

  always_comb begin
    if (mem_hit)     sel = SEL_MEM;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_REGFILE;
  end

  // the memory/writeback path is only taken when that stage really writes src
  always_comb begin
    if (!$isunknown({src, wb_wen, wb_dst}) && sel == SEL_WB)
      p_wb_only_when_written_r2: assert (wb_wen && wb_dst == src && src != '0);
  end
endmodule

// File: rtl/fwd_loaduse.sv
// Load-use hazard detection against the decode-stage sources.
module fwd_loaduse #(
  parameter int REG_AW  = 5,
  parameter int NUM_SRC = 2
) (
  input  logic              ld_valid,
  input  logic [REG_AW-1:0] ld_dst,
  input  logic [REG_AW-1:0] src [NUM_SRC],
  input  logic              use_src [NUM_SRC],
  output logic              stall
);
  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    fwd_hit #(.REG_AW(REG_AW)) u_hit (
      .src(src[i]), .dst(ld_dst), .wen(ld_valid && use_src[i]), .hit(hit[i])
    );
  end

  assign stall = |hit;

  always_comb begin
    if (!$isunknown({ld_valid, ld_dst}))
      p_no_stall_without_load_r8: assert (!stall || (ld_valid && ld_dst != '0));
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              wb_wen,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic [REG_AW-1:0] dec_src_a,
  input  logic [REG_AW-1:0] dec_src_b,
  input  logic              dec_use_a,
  input  logic              dec_use_b,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic              stall_req
);
  localparam int NUM_OPS = 2;

  logic [REG_AW-1:0] op_src [NUM_OPS];
  fwd_sel_e          op_sel [NUM_OPS];
  logic [REG_AW-1:0] dec_src [NUM_OPS];
  logic              dec_use [NUM_OPS];

  assign op_src[0]  = ex_src_a;
  assign op_src[1]  = ex_src_b;
  assign dec_src[0] = dec_src_a;
  assign dec_src[1] = dec_src_b;
  assign dec_use[0] = dec_use_a;
  assign dec_use[1] = dec_use_b;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    fwd_operand_sel #(.REG_AW(REG_AW)) u_sel (
      .src(op_src[k]), .mem_wen(mem_wen), .mem_dst(mem_dst),
      .wb_wen(wb_wen), .wb_dst(wb_dst), .sel(op_sel[k])
    );
  end

  assign sel_a = op_sel[0];
  assign sel_b = op_sel[1];

  fwd_loaduse #(.REG_AW(REG_AW), .NUM_SRC(NUM_OPS)) u_loaduse (
    .ld_valid(ex_is_load), .ld_dst(ex_dst), .src(dec_src),
    .use_src(dec_use), .stall(stall_req)
  );

  always_comb begin
    if (!$isunknown({ex_src_a, ex_src_b, mem_wen, mem_dst, wb_wen, wb_dst})) begin
      p_no_code11_r4: assert (sel_a != 2'b11 && sel_b != 2'b11);
      p_zero_src_a_r5: assert (ex_src_a != '0 || sel_a == 2'b00);
      p_zero_src_b_r5: assert (ex_src_b != '0 || sel_b == 2'b00);
      p_newer_wins_a_r3: assert (!(mem_wen && ex_src_a != '0 && mem_dst == ex_src_a)
                                 || sel_a == 2'b10);
      p_newer_wins_b_r3: assert (!(mem_wen && ex_src_b != '0 && mem_dst == ex_src_b)
                                 || sel_b == 2'b10);
      p_idle_regfile_r4: assert ((mem_wen || wb_wen) || (sel_a == 2'b00 && sel_b == 2'b00));
    end
  end
endmodule

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst, dec_src_a, dec_src_b;
  logic ex_is_load, mem_wen, wb_wen, dec_use_a, dec_use_b;
  logic [1:0] sel_a, sel_b;
  logic stall_req;

  int checks = 0;
  int errors = 0;

  fwd_unit #(.REG_AW(AW)) u_fwd_unit (.*);

  // datapath model: values held by register file, execute/memory and writeback
  localparam logic [31:0] RF_VAL = 32'd11, MEM_VAL = 32'd22, WB_VAL = 32'd33;
  function automatic logic [31:0] pick(input logic [1:0] s);
    case (s)
      2'b10:   return MEM_VAL;
      2'b01:   return WB_VAL;
      default: return RF_VAL;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ex_src_a = '0; ex_src_b = '0; ex_dst = '0; ex_is_load = 1'b0;
    mem_wen = 1'b0; mem_dst = '0; wb_wen = 1'b0; wb_dst = '0;
    dec_src_a = '0; dec_src_b = '0; dec_use_a = 1'b0; dec_use_b = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic t_idle();
    idle(); settle();
    chk("R4 idle sel_a", sel_a, 2'b00);
    chk("R4 idle sel_b", sel_b, 2'b00);
    chk("R8 idle stall", stall_req, 1'b0);
  endtask

  task automatic t_mem_fwd();
    idle(); ex_src_a = 5'd3; ex_src_b = 5'd4; mem_wen = 1; mem_dst = 5'd3; settle();
    chk("R1 sel_a", sel_a, 2'b10);
    chk("R1 alu operand a", pick(sel_a), MEM_VAL);
    chk("R6 sel_b untouched", sel_b, 2'b00);
  endtask

  task automatic t_wb_fwd();
    idle(); ex_src_b = 5'd7; wb_wen = 1; wb_dst = 5'd7; mem_wen = 1; mem_dst = 5'd9; settle();
    chk("R2 sel_b", sel_b, 2'b01);
    chk("R2 alu operand b", pick(sel_b), WB_VAL);
    chk("R2 sel_a reg0", sel_a, 2'b00);
  endtask

  task automatic t_priority();
    idle(); ex_src_a = 5'd5; ex_src_b = 5'd5;
    mem_wen = 1; mem_dst = 5'd5; wb_wen = 1; wb_dst = 5'd5; settle();
    chk("R3 sel_a newer wins", sel_a, 2'b10);
    chk("R3 sel_b newer wins", sel_b, 2'b10);
    mem_wen = 0; settle();
    chk("R3 falls to wb when mem not writing", sel_a, 2'b01);
  endtask

  task automatic t_wen_low();
    idle(); ex_src_a = 5'd6; ex_src_b = 5'd6; mem_dst = 5'd6; wb_dst = 5'd6; settle();
    chk("R4 wen low sel_a", sel_a, 2'b00);
    chk("R4 wen low sel_b", sel_b, 2'b00);
  endtask

  task automatic t_reg_zero();
    idle(); mem_wen = 1; wb_wen = 1; settle();
    chk("R5 zero src sel_a", sel_a, 2'b00);
    chk("R5 zero src sel_b", sel_b, 2'b00);
    chk("R5 zero alu operand", pick(sel_a), RF_VAL);
  endtask

  task automatic t_independent();
    idle(); ex_src_a = 5'd8; ex_src_b = 5'd12;
    mem_wen = 1; mem_dst = 5'd12; wb_wen = 1; wb_dst = 5'd8; settle();
    chk("R6 sel_a from wb", sel_a, 2'b01);
    chk("R6 sel_b from mem", sel_b, 2'b10);
  endtask

  task automatic t_loaduse();
    idle(); ex_is_load = 1; ex_dst = 5'd10; dec_src_a = 5'd10; dec_use_a = 1; settle();
    chk("R7 stall via src a", stall_req, 1'b1);
    dec_src_a = 5'd1; dec_src_b = 5'd10; dec_use_b = 1; settle();
    chk("R7 stall via src b", stall_req, 1'b1);
  endtask

  task automatic t_no_stall();
    idle(); ex_dst = 5'd10; dec_src_a = 5'd10; dec_use_a = 1; settle();
    chk("R8 not a load", stall_req, 1'b0);
    ex_is_load = 1; dec_use_a = 0; settle();
    chk("R8 source unused", stall_req, 1'b0);
    ex_dst = '0; dec_src_a = '0; dec_use_a = 1; settle();
    chk("R8 load to reg0", stall_req, 1'b0);
  endtask

  task automatic t_same_cycle();
    // R9: outputs change within the same cycle, without a clock edge
    idle(); ex_src_a = 5'd31; settle();
    mem_wen = 1; mem_dst = 5'd31; #1;
    chk("R9 immediate sel_a", sel_a, 2'b10);
    mem_wen = 0; #1;
    chk("R9 immediate release", sel_a, 2'b00);
  endtask

  task automatic t_sweep();
    for (int r = 0; r < 32; r++) begin
      idle(); ex_src_a = 5'(r); wb_wen = 1; wb_dst = 5'(r); settle();
      chk("R2 sweep sel_a", sel_a, (r == 0) ? 2'b00 : 2'b01);
    end
  endtask

  bit done = 0;
  initial begin
    idle();
    t_idle(); t_mem_fwd(); t_wb_fwd(); t_priority(); t_wen_low();
    t_reg_zero(); t_independent(); t_loaduse(); t_no_stall();
    t_same_cycle(); t_sweep();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule